// File: doc/BRIEF.md
# Programmed I/O Bridge With Buffered Output and Interrupting Input

This block sits on a simple processor bus (address, write strobe, read strobe, write data, read data) and serves one slow peripheral. Three fixed addresses select its functions. The output data port takes bytes from the processor at full bus speed. It queues them in a small FIFO and hands them to the device over a valid/ready handshake, one byte each time the device accepts. The input data port works the other way. A write to it is a fetch command. The block then asks the device for one byte, holds that byte, and raises an interrupt if interrupts are enabled. A read of the input port returns the held byte. The status/control port reports the block's state. Writes to the same address set the interrupt enable and clear the sticky error flag.

Two small state machines do the work. The input side has `RX_IDLE` and `RX_FETCH`. It moves from `RX_IDLE` to `RX_FETCH` on a fetch command. It moves from `RX_FETCH` back to `RX_IDLE` when the device presents a byte, which is captured on the same edge. The output side has `TX_IDLE` and `TX_OFFER`. It moves from `TX_IDLE` to `TX_OFFER` when the FIFO holds a byte, which it loads into the output register. In `TX_OFFER` it stays and reloads after a handshake while more bytes wait. It returns to `TX_IDLE` after a handshake that leaves the FIFO empty. The interrupt request stays up until the processor acknowledges it.

Top module: `pio_bridge`

## Requirements
- R1: Address map. A write to 16'hFFFE queues a byte for the device. A write to 16'hFFFF is a fetch command. A read of 16'hFFFF returns the held input byte and clears rx-valid. 16'hFFF7 is the status/control port. A write to any other address changes nothing, and a read of any other address returns 0.
- R2: Status byte layout: bit0 busy (fetch in progress), bit1 rx-valid, bit2 output FIFO full, bit3 error, bit4 interrupt enable, bits 7:5 zero. All bits are 0 after reset, and after reset `irq`, `dev_tx_valid` and `dev_rx_req` are 0.
- R3: A write to the status/control port stores data bit4 as the interrupt enable. Writing 1 to bit3 clears the error flag. All other written bits have no effect.
- R4: Busy and `dev_rx_req` are high from the edge after a fetch command until the edge on which a byte is captured. A fetch command issued while busy is ignored.
- R5: While busy, a byte with `dev_rx_valid` high is captured on that edge. On the same edge rx-valid is set and busy is cleared. `dev_rx_valid` while not busy is ignored.
- R6: When interrupt enable is 1, a capture or a device fault sets `irq`. `irq` holds until `irq_ack`, which clears it. If a new event coincides with `irq_ack`, `irq` stays set. With interrupt enable at 0, neither event raises `irq`.
- R7: Queued bytes reach the device in write order, one per cycle with `dev_tx_valid` and `dev_tx_ready` both high. While `dev_tx_valid` is high and `dev_tx_ready` low, the data are held.
- R8: The output path holds 4 FIFO entries plus one output register. The full bit is set when 4 bytes wait in the FIFO. A write to 16'hFFFE while full is dropped and sets the error flag.
- R9: A `dev_fault` pulse sets the error flag, which stays set until cleared as in R3.
- R10: Read data are registered. `bus_rdata` takes the selected value on the edge where `bus_rd` is sampled high and holds it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Processor address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge |
| dev_tx_data | output | 8 | Byte offered to the device |
| dev_tx_valid | output | 1 | Offered byte is valid |
| dev_tx_ready | input | 1 | Device accepts the offered byte |
| dev_rx_req | output | 1 | Request for one byte from the device |
| dev_rx_valid | input | 1 | Device presents a byte |
| dev_rx_data | input | 8 | Byte from the device |
| dev_fault | input | 1 | Device reports a fault |

## Verification
The bench fills the output path with the device stalled until a sixth byte overflows. A design that counted the output register as a FIFO slot, or kept the overflow byte, would show the wrong full bit or deliver a sixth byte. It issues a second fetch while busy and drives device data while idle. A design that restarted or captured in those cases would change busy or rx-valid. It also drives an acknowledge in the same cycle as a fault, and a design that let the acknowledge win would lose the new interrupt. It checks that stalled output data hold steady and that read data stay put between reads.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam logic [15:0] OUT_PORT_ADDR = 16'hFFFE;
    localparam logic [15:0] IN_PORT_ADDR  = 16'hFFFF;
    localparam logic [15:0] CSR_PORT_ADDR = 16'hFFF7;

    localparam int SB_BUSY = 0;
    localparam int SB_RXV  = 1;
    localparam int SB_FULL = 2;
    localparam int SB_ERR  = 3;
    localparam int SB_IE   = 4;

    typedef enum logic {RX_IDLE, RX_FETCH} rx_state_t;
    typedef enum logic {TX_IDLE, TX_OFFER} tx_state_t;
endpackage

// File: rtl/pio_txfifo.sv
module pio_txfifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          empty,
    output logic          full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= din;
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop)
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)
                count <= count + 1'b1;
            else if (do_pop && !do_push)
                count <= count - 1'b1;
        end
    end

    // R8: a push into a full queue with no pop leaves it full and unchanged
    assert_full_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);
endmodule

// File: rtl/pio_tx_drain.sv
module pio_tx_drain
    import pio_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          q_empty,
    input  logic [DW-1:0] q_dout,
    output logic          q_pop,
    output logic [DW-1:0] dev_tx_data,
    output logic          dev_tx_valid,
    input  logic          dev_tx_ready
);
    tx_state_t     state, state_n;
    logic          load;
    logic [DW-1:0] hold_q;

    always_comb begin
        state_n = state;
        load    = 1'b0;
        unique case (state)
            TX_IDLE: begin
                if (!q_empty) begin
                    load    = 1'b1;
                    state_n = TX_OFFER;
                end
            end
            TX_OFFER: begin
                if (dev_tx_ready) begin
                    if (!q_empty) load = 1'b1;
                    else          state_n = TX_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= TX_IDLE;
            hold_q <= '0;
        end else begin
            state <= state_n;
            if (load) hold_q <= q_dout;
        end
    end

    always_comb begin
        q_pop        = load;
        dev_tx_valid = (state == TX_OFFER);
        dev_tx_data  = hold_q;
    end

    // R7: an offered byte stays offered and unchanged until accepted
    assert_hold_stalled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_tx_valid && !dev_tx_ready) |=> (dev_tx_valid && $stable(dev_tx_data)));
endmodule

// File: rtl/pio_rx_fetch.sv
module pio_rx_fetch
    import pio_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_cmd,
    input  logic          dev_rx_valid,
    input  logic [DW-1:0] dev_rx_data,
    output logic          dev_rx_req,
    output logic          busy,
    output logic          cap,
    output logic [DW-1:0] cap_data
);
    rx_state_t state, state_n;

    always_comb begin
        state_n = state;
        unique case (state)
            RX_IDLE:  if (fetch_cmd)    state_n = RX_FETCH;
            RX_FETCH: if (dev_rx_valid) state_n = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        busy       = (state == RX_FETCH);
        dev_rx_req = busy;
        cap        = busy && dev_rx_valid;
        cap_data   = dev_rx_data;
    end

    // R4: a fetch command while idle makes the block busy on the next edge
    assert_cmd_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_cmd && !busy) |=> busy);
    // R5: a byte presented while busy ends the fetch
    assert_capture_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dev_rx_valid) |=> !busy);
endmodule

// File: rtl/pio_bridge.sv
module pio_bridge
    import pio_pkg::*;
#(
    parameter int          DW       = 8,
    parameter int          AW       = 16,
    parameter int          DEPTH    = 4,
    parameter logic [AW-1:0] OUT_ADDR = AW'(OUT_PORT_ADDR),
    parameter logic [AW-1:0] IN_ADDR  = AW'(IN_PORT_ADDR),
    parameter logic [AW-1:0] CSR_ADDR = AW'(CSR_PORT_ADDR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq,
    input  logic          irq_ack,
    output logic [DW-1:0] dev_tx_data,
    output logic          dev_tx_valid,
    input  logic          dev_tx_ready,
    output logic          dev_rx_req,
    input  logic          dev_rx_valid,
    input  logic [DW-1:0] dev_rx_data,
    input  logic          dev_fault
);
    logic          hit_out, hit_in, hit_csr;
    logic          wr_out, fetch_cmd, wr_csr;
    logic          q_empty, q_full, q_pop;
    logic [DW-1:0] q_dout;
    logic          busy, cap;
    logic [DW-1:0] cap_data;
    logic          ie_q, err_q, rxv_q, irq_q;
    logic [DW-1:0] rxbuf_q, status, rd_mux;
    logic          drop, irq_ev;

    assign hit_out   = (bus_addr == OUT_ADDR);
    assign hit_in    = (bus_addr == IN_ADDR);
    assign hit_csr   = (bus_addr == CSR_ADDR);
    assign wr_out    = bus_wr && hit_out;
    assign fetch_cmd = bus_wr && hit_in;
    assign wr_csr    = bus_wr && hit_csr;
    assign drop      = wr_out && q_full;
    assign irq_ev    = ie_q && (cap || dev_fault);

    pio_txfifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(wr_out), .din(bus_wdata),
        .pop(q_pop), .dout(q_dout), .empty(q_empty), .full(q_full)
    );

    pio_tx_drain #(.DW(DW)) u_drain (
        .clk(clk), .rst_n(rst_n), .q_empty(q_empty), .q_dout(q_dout),
        .q_pop(q_pop), .dev_tx_data(dev_tx_data), .dev_tx_valid(dev_tx_valid),
        .dev_tx_ready(dev_tx_ready)
    );

    pio_rx_fetch #(.DW(DW)) u_fetch (
        .clk(clk), .rst_n(rst_n), .fetch_cmd(fetch_cmd),
        .dev_rx_valid(dev_rx_valid), .dev_rx_data(dev_rx_data),
        .dev_rx_req(dev_rx_req), .busy(busy), .cap(cap), .cap_data(cap_data)
    );

    always_comb begin
        status          = '0;
        status[SB_BUSY] = busy;
        status[SB_RXV]  = rxv_q;
        status[SB_FULL] = q_full;
        status[SB_ERR]  = err_q;
        status[SB_IE]   = ie_q;
        if (hit_csr)     rd_mux = status;
        else if (hit_in) rd_mux = rxbuf_q;
        else             rd_mux = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q      <= 1'b0;
            err_q     <= 1'b0;
            rxv_q     <= 1'b0;
            irq_q     <= 1'b0;
            rxbuf_q   <= '0;
            bus_rdata <= '0;
        end else begin
            if (wr_csr) ie_q <= bus_wdata[SB_IE];
            if (drop || dev_fault)             err_q <= 1'b1;
            else if (wr_csr && bus_wdata[SB_ERR]) err_q <= 1'b0;
            if (cap) begin
                rxv_q   <= 1'b1;
                rxbuf_q <= cap_data;
            end else if (bus_rd && hit_in) begin
                rxv_q <= 1'b0;
            end
            if (irq_ev)       irq_q <= 1'b1;
            else if (irq_ack) irq_q <= 1'b0;
            if (bus_rd) bus_rdata <= rd_mux;
        end
    end

    assign irq = irq_q;

    // R8: a write dropped on a full queue leaves the error flag set
    assert_drop_sets_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_out && q_full) |=> err_q);
    // R6: a request stays up until acknowledged
    assert_irq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);
    // R6: an acknowledge with no new event drops the request
    assert_ack_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !(ie_q && (cap || dev_fault))) |=> !irq);
    // R10: read data change only after a read strobe
    assert_rdata_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/tb_pio_bridge.sv
`timescale 1ns/1ps
module tb_pio_bridge;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] bus_addr;
    logic        bus_wr, bus_rd;
    logic [7:0]  bus_wdata, bus_rdata;
    logic        irq, irq_ack;
    logic [7:0]  dev_tx_data;
    logic        dev_tx_valid, dev_tx_ready;
    logic        dev_rx_req, dev_rx_valid;
    logic [7:0]  dev_rx_data;
    logic        dev_fault;

    int total = 0;
    int bad   = 0;
    logic [7:0] got [8];
    int ngot;
    logic [7:0] rv;

    always #2 clk = ~clk;

    pio_bridge dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .irq_ack(irq_ack), .dev_tx_data(dev_tx_data),
        .dev_tx_valid(dev_tx_valid), .dev_tx_ready(dev_tx_ready),
        .dev_rx_req(dev_rx_req), .dev_rx_valid(dev_rx_valid),
        .dev_rx_data(dev_rx_data), .dev_fault(dev_fault)
    );

    // {addr, write data, expected status afterwards}
    localparam logic [31:0] VEC [5] = '{
        {16'hFFF7, 8'h10, 8'h10},
        {16'hFFF7, 8'h00, 8'h00},
        {16'hFFF7, 8'h10, 8'h10},
        {16'hFFF0, 8'hFF, 8'h10},
        {16'hFFF7, 8'hEF, 8'h00}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic dev_give(input logic [7:0] d);
        dev_rx_valid = 1'b1; dev_rx_data = d;
        @(negedge clk);
        dev_rx_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
        irq_ack = 0; dev_tx_ready = 0; dev_rx_valid = 0; dev_rx_data = '0; dev_fault = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 reset irq", irq, 0);
        chk("R2 reset tx_valid", dev_tx_valid, 0);
        chk("R2 reset rx_req", dev_rx_req, 0);
        bus_read(16'hFFF7, rv); chk("R2 reset status", rv, 8'h00);

        // R3 / R1: control writes and unmapped writes, read back through status
        for (int i = 0; i < 5; i++) begin
            bus_write(VEC[i][31:16], VEC[i][15:8]);
            bus_read(16'hFFF7, rv);
            chk("R3 status after control vector", rv, {24'h0, VEC[i][7:0]});
        end
        bus_read(16'hFFF0, rv); chk("R1 unmapped read", rv, 8'h00);

        // R4 / R5 / R6: fetch with interrupts enabled
        bus_write(16'hFFF7, 8'h10);
        bus_write(16'hFFFF, 8'h00);
        chk("R4 rx_req during fetch", dev_rx_req, 1);
        bus_read(16'hFFF7, rv); chk("R4 busy in status", rv, 8'h11);
        bus_write(16'hFFFF, 8'h00);
        chk("R4 second fetch ignored, still busy", dev_rx_req, 1);
        dev_give(8'hA5);
        chk("R6 irq after capture", irq, 1);
        chk("R4 rx_req dropped", dev_rx_req, 0);
        bus_read(16'hFFF7, rv); chk("R5 rx-valid set busy clear", rv, 8'h12);
        repeat (3) @(negedge clk);
        chk("R6 irq held", irq, 1);
        bus_read(16'hFFFF, rv); chk("R1 input byte", rv, 8'hA5);
        bus_read(16'hFFF7, rv); chk("R1 read clears rx-valid", rv, 8'h10);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        chk("R6 ack clears irq", irq, 0);
        dev_give(8'h3C);
        bus_read(16'hFFF7, rv); chk("R5 idle device data ignored", rv, 8'h10);
        bus_read(16'hFFFF, rv); chk("R5 buffer unchanged when idle", rv, 8'hA5);

        // R6: no interrupt when disabled
        bus_write(16'hFFF7, 8'h00);
        bus_write(16'hFFFF, 8'h00);
        dev_give(8'h5A);
        chk("R6 no irq when disabled", irq, 0);
        bus_read(16'hFFFF, rv); chk("R5 captured byte", rv, 8'h5A);

        // R9 / R6 / R3: device fault
        bus_write(16'hFFF7, 8'h10);
        dev_fault = 1'b1; @(negedge clk); dev_fault = 1'b0;
        chk("R6 irq on fault", irq, 1);
        bus_read(16'hFFF7, rv); chk("R9 error set", rv, 8'h18);
        irq_ack = 1'b1; dev_fault = 1'b1; @(negedge clk);
        irq_ack = 1'b0; dev_fault = 1'b0;
        chk("R6 event with ack keeps irq", irq, 1);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        chk("R6 ack alone clears", irq, 0);
        bus_write(16'hFFF7, 8'h10);
        bus_read(16'hFFF7, rv); chk("R9 error sticky without clear bit", rv, 8'h18);
        bus_write(16'hFFF7, 8'h18);
        bus_read(16'hFFF7, rv); chk("R3 error cleared by write-one", rv, 8'h10);

        // R7 / R8: burst with device stalled
        for (int i = 0; i < 6; i++) bus_write(16'hFFFE, 8'h11 + 8'(i));
        bus_read(16'hFFF7, rv); chk("R8 full and overflow error", rv, 8'h1C);
        chk("R7 first byte offered", dev_tx_valid, 1);
        repeat (3) @(negedge clk);
        chk("R7 stalled data held", dev_tx_data, 8'h11);
        ngot = 0;
        dev_tx_ready = 1'b1;
        for (int i = 0; i < 10; i++) begin
            if (dev_tx_valid && ngot < 8) begin
                got[ngot] = dev_tx_data;
                ngot++;
            end
            @(negedge clk);
        end
        dev_tx_ready = 1'b0;
        chk("R8 overflow byte dropped, count", ngot, 5);
        for (int i = 0; i < 5; i++)
            chk("R7 write order", got[i], 8'h11 + 8'(i));
        bus_read(16'hFFF7, rv); chk("R8 full clears after drain", rv, 8'h18);

        // R10: read data held between reads
        bus_write(16'hFFF7, 8'h08);
        chk("R10 rdata held", bus_rdata, 8'h18);
        bus_read(16'hFFF7, rv); chk("R10 new read", rv, 8'h00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule